// File: doc/BRIEF.md
# Multi-Channel Limit Monitor with Hysteresis

This block watches a stream of 12-bit conversion results, each tagged with one of four channel numbers. Every channel has a programmable ceiling, a programmable floor and a programmable hysteresis distance. For each channel the block keeps two alert bits, one for "above ceiling" and one for "below floor". Each bit sets as soon as a result crosses its limit. It clears only after a later result for the same channel has moved back inside by at least the hysteresis distance. A single active-high alert output combines all eight bits.

For each accepted result the block also builds the 16-bit word that a host reads back. The word carries a global alert flag, a zero bit, the channel number and the data. A reduced-resolution mode ignores the two lowest data bits, both in the limit comparisons and in the returned word. Limits, hysteresis values and the alert status are reached through a small register port. A clear command drops every alert bit.

Top module: `limalert_top`

## Requirements
- R1: After reset every ceiling register reads 0x0FFF, every floor and hysteresis register reads 0x0000, the status register reads 0, `alert` is low and `word_valid` is low.
- R2: The register address is {bank[1:0], channel[1:0]}: bank 0 holds the ceilings, bank 1 the floors, bank 2 the hysteresis values, and address 12 holds the status. Status bit c is the ceiling alert of channel c and bit 4+c is its floor alert. A write keeps only bits 11:0 and bits 15:12 read as zero. Writes to bank 3 have no effect, and addresses 13 to 15 read as zero. `reg_rdata` is combinational on `reg_addr`.
- R3: One clock after a result for channel c whose data is strictly greater than the ceiling of c, the ceiling alert of c is set.
- R4: A set ceiling alert clears one clock after a result for that channel whose data is at most ceiling − hysteresis. That threshold saturates at 0. A result above that threshold but not above the ceiling leaves the alert set.
- R5: A floor alert sets on data strictly less than the floor. It clears on data at least floor + hysteresis, a threshold that saturates at 0xFFF. Data between the floor and that threshold leaves the alert unchanged.
- R6: A result changes only the alert bits of the channel it is tagged with.
- R7: `alert` is high exactly when at least one of the eight alert bits is set.
- R8: `word_valid` pulses for one clock, one clock after `res_valid`. `word_out` then holds bit 14 = 0, bits 13:12 = the channel number and bits 11:0 = the data used for comparison.
- R9: Bit 15 of `word_out` is set when any channel, including the one just reported, has an active alert after that result has been applied. It equals `alert` in the same cycle.
- R10: `alert_clr` clears all eight alert bits one clock later. A violating result in the same cycle keeps the alert bit it sets.
- R11: With `mode_10b` high, bits 1:0 of the result are treated as zero, both in the limit comparisons and in `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Result strobe |
| res_chan | input | 2 | Channel number of the result |
| res_data | input | 12 | Conversion data |
| mode_10b | input | 1 | Reduced-resolution mode |
| alert_clr | input | 1 | Clear all alert bits |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register address {bank, channel} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| alert | output | 1 | Combined alert level |
| word_valid | output | 1 | Result word valid pulse |
| word_out | output | 16 | Host result word |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit data, 16-bit registers and two bits dropped in reduced mode. At that width the bench can place a ceiling a few codes above zero and a floor a few codes below full scale while using a large hysteresis. Both saturating thresholds, and the hold band inside them, are then reached with a handful of results. The bench also sends long random streams with limits, clears, writes and mode changes, and compares every cycle against a behavioural model.

// File: rtl/limalert_pkg.sv
package limalert_pkg;
  typedef enum logic [1:0] {
    BANK_CEIL = 2'd0,
    BANK_FLOOR = 2'd1,
    BANK_HYST = 2'd2,
    BANK_STAT = 2'd3
  } bank_e;
endpackage

// File: rtl/limalert_regs.sv
module limalert_regs
  import limalert_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int REG_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [$clog2(NUM_CH)+1:0]  addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [2*NUM_CH-1:0]        status,
  output logic [REG_W-1:0]           rdata,
  output logic [NUM_CH*DATA_W-1:0]   ceil_flat,
  output logic [NUM_CH*DATA_W-1:0]   floor_flat,
  output logic [NUM_CH*DATA_W-1:0]   hyst_flat
);
  localparam int CHW = $clog2(NUM_CH);
  localparam int AW  = CHW + 2;

  bank_e           bank;
  logic [CHW-1:0]  sel;
  logic [DATA_W-1:0] ceil_arr  [NUM_CH];
  logic [DATA_W-1:0] floor_arr [NUM_CH];
  logic [DATA_W-1:0] hyst_arr  [NUM_CH];

  assign bank = bank_e'(addr[AW-1 -: 2]);
  assign sel  = addr[CHW-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              ceil_en, floor_en, hyst_en;
    logic [DATA_W-1:0] ceil_q, floor_q, hyst_q;

    always_comb begin
      ceil_en  = wr_en && (bank == BANK_CEIL)  && (sel == CHW'(c));
      floor_en = wr_en && (bank == BANK_FLOOR) && (sel == CHW'(c));
      hyst_en  = wr_en && (bank == BANK_HYST)  && (sel == CHW'(c));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ceil_q  <= '1;
        floor_q <= '0;
        hyst_q  <= '0;
      end else begin
        if (ceil_en)  ceil_q  <= wdata[DATA_W-1:0];
        if (floor_en) floor_q <= wdata[DATA_W-1:0];
        if (hyst_en)  hyst_q  <= wdata[DATA_W-1:0];
      end
    end

    assign ceil_arr[c]  = ceil_q;
    assign floor_arr[c] = floor_q;
    assign hyst_arr[c]  = hyst_q;
    assign ceil_flat[c*DATA_W +: DATA_W]  = ceil_q;
    assign floor_flat[c*DATA_W +: DATA_W] = floor_q;
    assign hyst_flat[c*DATA_W +: DATA_W]  = hyst_q;
  end

  always_comb begin
    rdata = '0;
    unique case (bank)
      BANK_CEIL:  rdata = {{(REG_W-DATA_W){1'b0}}, ceil_arr[sel]};
      BANK_FLOOR: rdata = {{(REG_W-DATA_W){1'b0}}, floor_arr[sel]};
      BANK_HYST:  rdata = {{(REG_W-DATA_W){1'b0}}, hyst_arr[sel]};
      BANK_STAT:  if (sel == '0) rdata = {{(REG_W-2*NUM_CH){1'b0}}, status};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/limalert_chan.sv
module limalert_chan #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] ceil_lim,
  input  logic [DATA_W-1:0] floor_lim,
  input  logic [DATA_W-1:0] hyst,
  input  logic              clr,
  output logic              hi_alert,
  output logic              lo_alert,
  output logic              hi_nxt,
  output logic              lo_nxt
);
  logic              over, under, back_hi, back_lo, upd_en;
  logic [DATA_W-1:0] hi_release, lo_release;
  logic [DATA_W:0]   lo_sum;
  logic              hi_q, lo_q;

  // Release thresholds, clamped to the code range
  always_comb begin
    hi_release = (ceil_lim >= hyst) ? (ceil_lim - hyst) : '0;
    lo_sum     = {1'b0, floor_lim} + {1'b0, hyst};
    lo_release = lo_sum[DATA_W] ? '1 : lo_sum[DATA_W-1:0];
    over       = data > ceil_lim;
    under      = data < floor_lim;
    back_hi    = data <= hi_release;
    back_lo    = data >= lo_release;
  end

  // Next state: a new violation wins over a clear
  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (hit && over)         hi_nxt = 1'b1;
    else if (clr)            hi_nxt = 1'b0;
    else if (hit && back_hi) hi_nxt = 1'b0;
    if (hit && under)        lo_nxt = 1'b1;
    else if (clr)            lo_nxt = 1'b0;
    else if (hit && back_lo) lo_nxt = 1'b0;
    upd_en = hit || clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (upd_en) begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assign hi_alert = hi_q;
  assign lo_alert = lo_q;
endmodule

// File: rtl/limalert_word.sv
module limalert_word #(
  parameter int DATA_W = 12,
  parameter int CHW    = 2,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CHW-1:0]    chan,
  input  logic [DATA_W-1:0] data,
  input  logic              flag,
  output logic              word_valid,
  output logic [REG_W-1:0]  word_out
);
  logic [REG_W-1:0] word_d, word_q;
  logic             vld_q;

  always_comb begin
    word_d = {flag, 1'b0, chan, data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q <= valid;
      if (valid) word_q <= word_d;
    end
  end

  assign word_valid = vld_q;
  assign word_out   = word_q;
endmodule

// File: rtl/limalert_top.sv
module limalert_top #(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 12,
  parameter int REG_W       = 16,
  parameter int NARROW_DROP = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        res_valid,
  input  logic [$clog2(NUM_CH)-1:0]   res_chan,
  input  logic [DATA_W-1:0]           res_data,
  input  logic                        mode_10b,
  input  logic                        alert_clr,
  input  logic                        reg_wr,
  input  logic [$clog2(NUM_CH)+1:0]   reg_addr,
  input  logic [REG_W-1:0]            reg_wdata,
  output logic [REG_W-1:0]            reg_rdata,
  output logic                        alert,
  output logic                        word_valid,
  output logic [REG_W-1:0]            word_out
);
  localparam int CHW = $clog2(NUM_CH);

  logic [DATA_W-1:0]          data_eff;
  logic [NUM_CH*DATA_W-1:0]   ceil_flat, floor_flat, hyst_flat;
  logic [2*NUM_CH-1:0]        alert_vec, nxt_vec;
  logic                       flag_nxt;

  always_comb begin
    data_eff = res_data;
    if (mode_10b) data_eff[NARROW_DROP-1:0] = '0;
  end

  limalert_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .status     (alert_vec),
    .rdata      (reg_rdata),
    .ceil_flat  (ceil_flat),
    .floor_flat (floor_flat),
    .hyst_flat  (hyst_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mon
    logic hit;
    assign hit = res_valid && (res_chan == CHW'(c));
    limalert_chan #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .data      (data_eff),
      .ceil_lim  (ceil_flat[c*DATA_W +: DATA_W]),
      .floor_lim (floor_flat[c*DATA_W +: DATA_W]),
      .hyst      (hyst_flat[c*DATA_W +: DATA_W]),
      .clr       (alert_clr),
      .hi_alert  (alert_vec[c]),
      .lo_alert  (alert_vec[NUM_CH+c]),
      .hi_nxt    (nxt_vec[c]),
      .lo_nxt    (nxt_vec[NUM_CH+c])
    );
  end

  assign flag_nxt = |nxt_vec;
  assign alert    = |alert_vec;

  limalert_word #(.DATA_W(DATA_W), .CHW(CHW), .REG_W(REG_W)) u_word (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (res_valid),
    .chan       (res_chan),
    .data       (data_eff),
    .flag       (flag_nxt),
    .word_valid (word_valid),
    .word_out   (word_out)
  );
endmodule

// File: rtl/limalert_chk.sv
module limalert_chk #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 12,
  parameter int REG_W  = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       res_valid,
  input logic [$clog2(NUM_CH)-1:0]  res_chan,
  input logic [DATA_W-1:0]          res_data,
  input logic                       mode_10b,
  input logic                       alert_clr,
  input logic                       alert,
  input logic                       word_valid,
  input logic [REG_W-1:0]           word_out,
  input logic [NUM_CH*DATA_W-1:0]   ceil_flat,
  input logic [2*NUM_CH-1:0]        alert_vec
);
  localparam int CHW = $clog2(NUM_CH);

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> word_valid);

  a_r8_chan_id: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (word_out[DATA_W +: CHW] == $past(res_chan)));

  a_r9_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_out[REG_W-1] == alert));

  a_r3_ceil_set: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !mode_10b && (res_data > ceil_flat[res_chan*DATA_W +: DATA_W]))
      |=> alert);

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_clr && !res_valid) |=> (alert_vec == '0));

  a_r11_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && mode_10b) |=> (word_out[1:0] == 2'b00));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hold
    a_r6_other_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(res_valid && res_chan == CHW'(c)) && !alert_clr)
        |=> ($stable(alert_vec[c]) && $stable(alert_vec[NUM_CH+c])));
  end
endmodule

bind limalert_top limalert_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_chan   (res_chan),
  .res_data   (res_data),
  .mode_10b   (mode_10b),
  .alert_clr  (alert_clr),
  .alert      (alert),
  .word_valid (word_valid),
  .word_out   (word_out),
  .ceil_flat  (ceil_flat),
  .alert_vec  (alert_vec)
);

// File: tb/tb_limalert_top.sv
module tb_limalert_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        res_valid, mode_10b, alert_clr, reg_wr;
  logic [1:0]  res_chan;
  logic [11:0] res_data;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, word_out;
  logic        alert, word_valid;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  int mceil[4], mfloor[4], mhyst[4];
  bit mhi[4], mlo[4];
  bit exp_v;
  int exp_w;

  limalert_top dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .mode_10b(mode_10b), .alert_clr(alert_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alert(alert), .word_valid(word_valid),
    .word_out(word_out)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic int mstatus();
    int s = 0;
    for (int c = 0; c < 4; c++) begin
      if (mhi[c]) s |= (1 << c);
      if (mlo[c]) s |= (1 << (4 + c));
    end
    return s;
  endfunction

  function automatic int mread(input int a);
    int b = (a >> 2) & 3;
    int c = a & 3;
    case (b)
      0: return mceil[c];
      1: return mfloor[c];
      2: return mhyst[c];
      default: return (c == 0) ? mstatus() : 0;
    endcase
  endfunction

  task automatic model_step(input bit v, input int ch, input int d, input bit clr,
                            input bit wr, input int a, input int wd, input bit m10);
    int d2 = m10 ? (d & 'hFFC) : d;
    for (int c = 0; c < 4; c++) begin
      int hrel = mceil[c] - mhyst[c];
      int lrel = mfloor[c] + mhyst[c];
      if (hrel < 0) hrel = 0;
      if (lrel > 'hFFF) lrel = 'hFFF;
      if (v && ch == c) begin
        if (d2 > mceil[c]) mhi[c] = 1;
        else if (clr) mhi[c] = 0;
        else if (d2 <= hrel) mhi[c] = 0;
        if (d2 < mfloor[c]) mlo[c] = 1;
        else if (clr) mlo[c] = 0;
        else if (d2 >= lrel) mlo[c] = 0;
      end else if (clr) begin
        mhi[c] = 0;
        mlo[c] = 0;
      end
    end
    exp_v = v;
    if (v) exp_w = ((mstatus() != 0) << 15) | ((ch & 3) << 12) | d2;
    if (wr) begin
      case ((a >> 2) & 3)
        0: mceil[a & 3]  = wd & 'hFFF;
        1: mfloor[a & 3] = wd & 'hFFF;
        2: mhyst[a & 3]  = wd & 'hFFF;
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit v, input int ch, input int d, input bit clr,
                     input bit wr, input int a, input int wd, input bit m10);
    res_valid = v; res_chan = ch[1:0]; res_data = d[11:0]; alert_clr = clr;
    reg_wr = wr; reg_addr = a[3:0]; reg_wdata = wd[15:0]; mode_10b = m10;
    @(posedge clk);
    model_step(v, ch, d, clr, wr, a, wd, m10);
    #1;
    chk(alert == (mstatus() != 0), "R7 alert level", alert, mstatus() != 0);
    chk(word_valid == exp_v, "R8 word_valid", word_valid, exp_v);
    if (exp_v) begin
      chk(word_out[14:0] == exp_w[14:0], "R8 word body", word_out, exp_w);
      chk(word_out[15] == exp_w[15], "R9 alert flag", word_out[15], exp_w[15]);
    end
    chk(reg_rdata == mread(a), "R2 register read", reg_rdata, mread(a));
  endtask

  task automatic res(input int ch, input int d);
    cyc(1, ch, d, 0, 0, 12, 0, 0);
  endtask

  task automatic wreg(input int a, input int wd);
    cyc(0, 0, 0, 0, 1, a, wd, 0);
  endtask

  task automatic rd(input int a, input int expv, input string tag);
    cyc(0, 0, 0, 0, 0, a, 0, 0);
    chk(reg_rdata == expv[15:0], tag, reg_rdata, expv);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      mceil[c] = 'hFFF; mfloor[c] = 0; mhyst[c] = 0; mhi[c] = 0; mlo[c] = 0;
    end
    exp_v = 0; exp_w = 0;
    rst_n = 0; res_valid = 0; res_chan = 0; res_data = 0; mode_10b = 0;
    alert_clr = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(alert == 0, "R1 alert after reset", alert, 0);
    chk(word_valid == 0, "R1 word_valid after reset", word_valid, 0);
    for (int a = 0; a < 13; a++)
      rd(a, (a < 4) ? 'hFFF : 0, "R1 reset register value");

    // R2 writes, width, ignored bank
    wreg(0, 'h0800); wreg(8, 'h0010);
    rd(0, 'h800, "R2 ceiling readback");
    wreg(5, 'hF123);
    rd(5, 'h123, "R2 upper bits read zero");
    wreg(13, 'hFFFF);
    rd(13, 0, "R2 bank 3 write ignored");
    rd(12, 0, "R2 status unaffected by bank 3 write");

    // R3 / R4 ceiling set, hold band, release
    res(0, 'h801);
    rd(12, 'h001, "R3 ceiling alert set");
    res(0, 'h7F5);
    rd(12, 'h001, "R4 hold inside hysteresis");
    res(0, 'h7F0);
    rd(12, 'h000, "R4 release at ceiling minus N");

    // R4 saturating release threshold
    wreg(2, 'h005); wreg(10, 'h010);
    res(2, 'h006);
    rd(12, 'h004, "R4 small ceiling set");
    res(2, 'h001);
    rd(12, 'h004, "R4 saturated threshold hold");
    res(2, 'h000);
    rd(12, 'h000, "R4 saturated threshold release");

    // R5 floor with hysteresis and saturation
    wreg(9, 'h020);
    res(1, 'h122);
    rd(12, 'h020, "R5 floor alert set");
    res(1, 'h142);
    rd(12, 'h020, "R5 hold below floor plus N");
    res(1, 'h143);
    rd(12, 'h000, "R5 release at floor plus N");
    wreg(7, 'hFF0); wreg(11, 'h100);
    res(3, 'hFEF);
    rd(12, 'h080, "R5 high floor set");
    res(3, 'hFFE);
    rd(12, 'h080, "R5 saturated threshold hold");
    res(3, 'hFFF);
    rd(12, 'h000, "R5 saturated threshold release");

    // R6 other channels untouched
    res(0, 'h900);
    res(1, 'h500);
    rd(12, 'h001, "R6 other channel result leaves alert");

    // R10 clear with simultaneous violation
    res(2, 'h100);
    rd(12, 'h005, "R10 two alerts before clear");
    cyc(1, 0, 'h900, 1, 0, 12, 0, 0);
    chk(reg_rdata == 'h001, "R10 violation survives clear", reg_rdata, 'h001);
    cyc(0, 0, 0, 1, 0, 12, 0, 0);
    chk(reg_rdata == 0 && alert == 0, "R10 clear drops all", reg_rdata, 0);

    // R11 reduced mode
    cyc(1, 0, 'h803, 0, 0, 12, 0, 1);
    chk(word_out[1:0] == 0, "R11 low bits zero", word_out[1:0], 0);
    chk(word_out[11:0] == 'h800, "R11 data truncated", word_out[11:0], 'h800);
    chk(reg_rdata == 0, "R11 truncated value does not exceed ceiling", reg_rdata, 0);
    res(0, 'h801);
    chk(reg_rdata == 'h001, "R11 full mode sees excess", reg_rdata, 'h001);

    // random phase against the model (R3-R10 combined)
    for (int i = 0; i < 4000; i++) begin
      int ch = $urandom_range(0, 3);
      int sel = $urandom_range(0, 7);
      int d;
      int hy;
      case (sel)
        0: d = 0;
        1: d = 'hFFF;
        2: d = mceil[ch] + $urandom_range(0, 40) - 20;
        3: d = mfloor[ch] + $urandom_range(0, 40) - 20;
        default: d = $urandom_range(0, 'hFFF);
      endcase
      if (d < 0) d = 0;
      if (d > 'hFFF) d = 'hFFF;
      hy = $urandom_range(0, 'hFFF);
      if ($urandom_range(0, 1) == 0) hy = $urandom_range(0, 48);
      cyc($urandom_range(0, 3) != 0, ch, d, $urandom_range(0, 15) == 0,
          $urandom_range(0, 12) == 0, $urandom_range(0, 15),
          ($urandom_range(0, 3) == 0) ? $urandom_range(0, 'hFFFF) :
            ($urandom_range(0, 1) ? (mread(ch) ^ $urandom_range(0, 'h3F)) : hy),
          $urandom_range(0, 3) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule